// File: doc/BRIEF.md
# Reset Cause Status Register

This block records which event caused the most recent system reset, so that start-up software can tell apart a cold start, a warm reset from the pin, a watchdog expiry, a fault in the instruction stream, a monitor-mode entry and a supply dip. Seven reset-source flags come from the reset controller and stay valid while the system reset is held. The block samples them in the cycle the reset is released. A power-on event always wins and leaves only its own bit set. Software reads the status through a small synchronous register port, and the read clears the status.

A second register holds one writable bit, the break-clear enable. While a debugger holds the processor in a break state, a status read still returns the data. The read clears the bits only if software has set this enable. This lets a debugger inspect the status without destroying it. The block's own power-on reset (`por_n`) is asynchronous and active low. The system reset (`sys_rst_active`) is a synchronous level driven by the reset controller.

Top module: `reset_cause_reg`

## Requirements
- R1: Status bit i stands for source i, with this mapping: 0 power-on, 1 external pin, 2 watchdog timeout, 3 illegal opcode, 4 opcode fetch from an unimplemented address, 5 monitor-mode entry (both reset vector bytes read as all-ones), 6 low-voltage. Status bit 7 always reads 0.
- R2: The status loads the `rst_src` flags at the first clock edge at which `sys_rst_active` is low after having been high. Between such releases, only a clearing read changes it.
- R3: Asserting `por_n` low sets the status to 0x01. A release with `rst_src[0]` set also loads 0x01, whatever the other flags are.
- R4: Outside the break state, a read strobe at the status address (address 0) returns the status on `rdata` in that same cycle and clears every status bit at the closing clock edge.
- R5: When several non-power-on flags are set at a release, every one of the matching bits is set.
- R6: While `brk_active` is 1 and the enable is 0, a status read returns the data and leaves the status unchanged.
- R7: While `brk_active` is 1 and the enable is 1, a status read clears the status.
- R8: The control register is at address 1. Bit 7 is the break-clear enable, written from `wdata[7]` and read back on `rdata[7]`. Bits 6 to 0 read as 0.
- R9: Writes to the status address have no effect.
- R10: The enable is 0 after `por_n`, and it is forced to 0 while `sys_rst_active` is high. Bus strobes are ignored while `sys_rst_active` is high.
- R11: A read at any other address returns 0 and does not clear the status. `rdata` is 0 whenever no read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset of this block |
| sys_rst_active | input | 1 | High while the system reset is held |
| rst_src | input | 7 | Reset-source flags, valid while the reset is held |
| brk_active | input | 1 | Processor is in a debug break state |
| addr | input | ADDR_W | Register address |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |

## Verification
The capture path is exercised with a lone external-pin flag, with a mix of three warm-reset flags, and with every flag set together. These cases separate per-bit loading, bit-order errors and the precedence of the power-on flag. Clear-on-read is tried in and out of the break state with the enable at both values, which isolates the gating term. Writes to the status, reads of unmapped addresses and a system reset that follows a set enable show that none of these side paths disturbs the registers.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int SRC_N  = 7;
  localparam int DATA_W = 8;
  localparam int SRC_POWER_ON = 0;
  localparam int CTRL_EN_BIT  = 7;
  typedef enum logic [1:0] {SEL_NONE, SEL_STAT, SEL_CTRL} rcs_sel_e;
endpackage

// File: rtl/rcs_decode.sv
module rcs_decode
  import rcs_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bus_ok,
  input  logic              rd_en,
  input  logic              wr_en,
  output rcs_sel_e          rd_sel,
  output logic              wr_ctrl
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  always_comb begin
    rd_sel = SEL_NONE;
    if (bus_ok && rd_en) begin
      if (addr == STAT_A)      rd_sel = SEL_STAT;
      else if (addr == CTRL_A) rd_sel = SEL_CTRL;
    end
    wr_ctrl = bus_ok && wr_en && (addr == CTRL_A);
  end
endmodule

// File: rtl/rcs_status.sv
module rcs_status
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             release_i,
  input  logic [SRC_N-1:0] src_i,
  input  logic             clr_i,
  output logic [SRC_N-1:0] status_o
);
  localparam logic [SRC_N-1:0] PON_ONLY = SRC_N'(1) << SRC_POWER_ON;

  logic [SRC_N-1:0] status_q, status_d;
  logic             load;

  always_comb begin
    load     = release_i | clr_i;
    status_d = '0;
    if (release_i) status_d = src_i[SRC_POWER_ON] ? PON_ONLY : src_i;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    status_q <= PON_ONLY;
    else if (load) status_q <= status_d;
  end

  assign status_o = status_q;

  a_r3_power_on_wins: assert property (@(posedge clk) disable iff (!por_n)
    release_i && src_i[SRC_POWER_ON] |=> status_o == PON_ONLY);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!por_n)
    clr_i && !release_i |=> status_o == '0);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!por_n)
    !release_i && !clr_i |=> $stable(status_o));
endmodule

// File: rtl/rcs_brkctl.sv
module rcs_brkctl (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic en_o
);
  logic en_q, en_d, en_ld;

  always_comb begin
    en_ld = sys_rst_i | wr_i;
    en_d  = sys_rst_i ? 1'b0 : wbit_i;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     en_q <= 1'b0;
    else if (en_ld) en_q <= en_d;
  end

  assign en_o = en_q;

  a_r10_enable_cleared: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_i |=> !en_o);
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcs_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_active,
  input  logic [6:0]        rst_src,
  input  logic              brk_active,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int PAD_W = DATA_W - SRC_N;

  logic             rst_q;
  logic             release_w;
  rcs_sel_e         rd_sel;
  logic             wr_ctrl;
  logic             brk_en;
  logic             clr_ok;
  logic [SRC_N-1:0] status;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_q <= 1'b0;
    else        rst_q <= sys_rst_active;
  end

  assign release_w = rst_q & ~sys_rst_active;

  rcs_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_decode (
    .addr(addr), .bus_ok(~sys_rst_active), .rd_en(rd_en), .wr_en(wr_en),
    .rd_sel(rd_sel), .wr_ctrl(wr_ctrl)
  );

  rcs_brkctl u_brkctl (
    .clk(clk), .por_n(por_n), .sys_rst_i(sys_rst_active),
    .wr_i(wr_ctrl), .wbit_i(wdata[CTRL_EN_BIT]), .en_o(brk_en)
  );

  assign clr_ok = (rd_sel == SEL_STAT) && (!brk_active || brk_en);

  rcs_status u_status (
    .clk(clk), .por_n(por_n), .release_i(release_w), .src_i(rst_src),
    .clr_i(clr_ok), .status_o(status)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_STAT: rdata = {{PAD_W{1'b0}}, status};
      SEL_CTRL: rdata = {brk_en, {(DATA_W-1){1'b0}}};
      default:  rdata = '0;
    endcase
  end

  a_r6_break_holds: assert property (@(posedge clk) disable iff (!por_n)
    rd_en && addr == ADDR_W'(STAT_ADDR) && !sys_rst_active && brk_active && !brk_en && !release_w
    |=> $stable(status));
  a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (!por_n)
    wr_en && !rd_en && !release_w |=> $stable(status));
  a_r11_unmapped_no_clear: assert property (@(posedge clk) disable iff (!por_n)
    rd_en && addr != ADDR_W'(STAT_ADDR) && !release_w |=> $stable(status));
  a_r11_idle_bus_zero: assert property (@(posedge clk) disable iff (!por_n)
    !rd_en |-> rdata == 8'h00);
endmodule

// File: tb/test_reset_cause_reg.sv
`timescale 1ns/100ps
module test_reset_cause_reg;
  logic       clk = 1'b0;
  logic       por_n;
  logic       sys_rst_active;
  logic [6:0] rst_src;
  logic       brk_active;
  logic [3:0] addr;
  logic       rd_en, wr_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  reset_cause_reg i_reset_cause_reg (
    .clk(clk), .por_n(por_n), .sys_rst_active(sys_rst_active), .rst_src(rst_src),
    .brk_active(brk_active), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sys_reset(input logic [6:0] src);
    @(negedge clk);
    sys_rst_active = 1'b1; rst_src = src;
    repeat (3) @(negedge clk);
    sys_rst_active = 1'b0;
    @(negedge clk);
    rst_src = '0;
  endtask

  task automatic t_power_on;
    logic [7:0] d;
    bus_read(4'd0, d); check("R3 power-on value", d, 8'h01);
    bus_read(4'd0, d); check("R4 cleared after read", d, 8'h00);
    bus_read(4'd1, d); check("R10 enable after power-on", d, 8'h00);
    #1 check("R11 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_single_pin;
    logic [7:0] d;
    sys_reset(7'h02);
    bus_read(4'd0, d); check("R1 R2 pin source", d, 8'h02);
    bus_read(4'd0, d); check("R4 clear after pin", d, 8'h00);
  endtask

  task automatic t_multi;
    logic [7:0] d;
    sys_reset(7'h64);
    bus_read(4'd0, d); check("R5 R1 multiple sources", d, 8'h64);
  endtask

  task automatic t_por_source;
    logic [7:0] d;
    sys_reset(7'h7F);
    bus_read(4'd0, d); check("R3 power-on flag wins", d, 8'h01);
  endtask

  task automatic t_write_ignored;
    logic [7:0] d;
    sys_reset(7'h10);
    bus_write(4'd0, 8'hFF);
    bus_write(4'd0, 8'h00);
    bus_read(4'd5, d); check("R11 unmapped read", d, 8'h00);
    bus_read(4'd0, d); check("R9 R11 status after write", d, 8'h10);
  endtask

  task automatic t_break_hold;
    logic [7:0] d;
    sys_reset(7'h08);
    brk_active = 1'b1;
    bus_read(4'd0, d); check("R6 data during break", d, 8'h08);
    bus_read(4'd0, d); check("R6 not cleared in break", d, 8'h08);
    brk_active = 1'b0;
    bus_read(4'd0, d); check("R4 read after break", d, 8'h08);
    bus_read(4'd0, d); check("R4 cleared after break", d, 8'h00);
  endtask

  task automatic t_break_clear;
    logic [7:0] d;
    sys_reset(7'h20);
    bus_write(4'd1, 8'hFF);
    bus_read(4'd1, d); check("R8 control readback", d, 8'h80);
    brk_active = 1'b1;
    bus_read(4'd0, d); check("R7 data in break", d, 8'h20);
    bus_read(4'd0, d); check("R7 cleared in break", d, 8'h00);
    brk_active = 1'b0;
    bus_write(4'd1, 8'h7F);
    bus_read(4'd1, d); check("R8 enable written 0", d, 8'h00);
  endtask

  task automatic t_enable_reset;
    logic [7:0] d;
    bus_write(4'd1, 8'h80);
    sys_reset(7'h04);
    bus_read(4'd1, d); check("R10 enable cleared by reset", d, 8'h00);
    bus_read(4'd0, d); check("R1 watchdog source", d, 8'h04);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    por_n = 1'b0; sys_rst_active = 1'b0; rst_src = '0; brk_active = 1'b0;
    addr = '0; rd_en = 1'b0; wr_en = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_power_on();
    t_single_pin();
    t_multi();
    t_por_source();
    t_write_ignored();
    t_break_hold();
    t_break_clear();
    t_enable_reset();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule